// File: doc/BRIEF.md
# Issue-Queue Operand Readiness Tracker

This block holds the readiness state of every source operand of a single issue-queue entry in an out-of-order core. It watches the wakeup broadcasts. A broadcast can come from writeback, which is certain, or from an early issue-queue wakeup, which is speculative. The block marks a source ready when the broadcast's destination tag equals the source's physical tag and the broadcast writes the register class that the source reads.

A speculative wakeup leaves two pieces of state in the source. The first is a per-load-pipeline dependency vector that moves up by one bit every cycle, so its bit position tells how many stages old the producing load is. The second is the one-hot of the execution unit that woke the source, kept together with a small saturating age timer. Readiness is withdrawn when one of three things happens:
- a load pipeline reports a late miss at the stage the dependency points to;
- the producing unit's issue is cancelled in operand-gather stage 0 exactly one cycle after the wakeup;
- a tagged cancel broadcast names the source.

Allocation loads the tag, class and initial readiness of all sources at once.

Top module: `wakeup_cancel_tracker`

## Requirements
- R1: After synchronous reset every `src_ready_o` bit is 0 and `cancel_o` is 0.
- R2: Allocation loads each source's tag, class (0 integer, 1 floating point, 2 vector, 3 non-register) and ready bit. A non-register source reports ready whatever its state bit is. Allocation overrides a wakeup or a cancel in the same cycle.
- R3: A wakeup port hits a source only when all of these hold: the port is valid, the port's tag equals the source tag, and the port's write-enable bit for the source class is set. The write-enable bits are bit 0 integer, bit 1 floating point and bit 2 vector. A port that fails any of these conditions leaves the source unchanged.
- R4: `src_ready_o` rises at the clock edge that ends the cycle in which the hit is presented.
- R5: On a hit the source captures the hitting port's 3-bit dependency field for each load pipeline. Every later cycle each field shifts left by one bit, and any bit shifted beyond bit 2 is lost.
- R6: A stage-1 load cancel on pipeline p cancels a ready source whose dependency field for p has bit 1 set. A cancel on a different pipeline has no effect.
- R7: A stage-2 load cancel on pipeline p cancels a ready source whose dependency field for p has bit 2 set.
- R8: On a hit the source captures the port's unit one-hot and starts a timer at 0. The timer counts up once per cycle and stops at 7. An og0 cancel one-hot cancels the source when it overlaps the stored one-hot while the timer reads 1.
- R9: A cancel broadcast whose tag matches a ready source cancels it in two cases: an integer source when the broadcast's integer flag is 1, and a floating-point or vector source when that flag is 0.
- R10: `cancel_o` is high in the same cycle that any ready register source meets a cancel condition. That source's ready bit, dependency fields and timer are zero after the next edge, and a source that is not ready cannot be cancelled.
- R11: A hit in the same cycle as a cancel wins: the source stays ready and takes the new wakeup's dependency and timer.
- R12: When several ports hit one source in the same cycle, the lowest-numbered port supplies the captured dependency and one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_i | input | 1 | Load a new entry's source descriptors |
| alloc_tag_i | input | NUM_SRC*TAG_W | Physical tag per source |
| alloc_kind_i | input | NUM_SRC*2 | Class per source |
| alloc_rdy_i | input | NUM_SRC | Initial ready bit per source |
| wk_valid_i | input | NUM_WK | Wakeup port valid |
| wk_tag_i | input | NUM_WK*TAG_W | Wakeup destination tag |
| wk_wen_i | input | NUM_WK*3 | Per-port class write enables |
| wk_exu_oh_i | input | NUM_WK*NUM_EXU | Producing unit one-hot (zero for writeback) |
| wk_ldep_i | input | NUM_WK*NUM_LDP*3 | Dependency field, port w pipe p at bits (w*NUM_LDP+p)*3 |
| ldc1_i | input | NUM_LDP | Stage-1 load cancel per pipeline |
| ldc2_i | input | NUM_LDP | Stage-2 load cancel per pipeline |
| og0_cancel_i | input | NUM_EXU | Operand-gather stage-0 cancel one-hot |
| cb_valid_i | input | 1 | Cancel broadcast valid |
| cb_tag_i | input | TAG_W | Cancel broadcast tag |
| cb_int_i | input | 1 | Cancel broadcast integer flag |
| src_ready_o | output | NUM_SRC | Per-source ready |
| cancel_o | output | 1 | A ready source is being revoked this cycle |

## Verification
Each result has a fixed timing:
- `cancel_o` is combinational from the stored state and the cancel inputs, so it is sampled a few nanoseconds after the stimulus is driven and before the next rising edge.
- `src_ready_o` is sampled just after the edge that closes the stimulus cycle.
- Dependency and timer ages are counted in whole idle cycles after the capturing edge. A wakeup followed by k idle cycles sees dependency `d<<k` and timer `min(k,7)`, and the sweeps compute every expected cancel from those two formulas.

// File: rtl/wct_pkg.sv
package wct_pkg;

    localparam int DEP_W   = 3;
    localparam int TMR_W   = 3;
    localparam int TMR_TOP = 7;

    typedef enum logic [1:0] {
        KIND_INT = 2'd0,
        KIND_FP  = 2'd1,
        KIND_VEC = 2'd2,
        KIND_IMM = 2'd3
    } src_kind_e;

    typedef struct packed {
        logic vec_en;
        logic fp_en;
        logic int_en;
    } wen_t;

    function automatic logic class_hit(src_kind_e k, wen_t w);
        case (k)
            KIND_INT: class_hit = w.int_en;
            KIND_FP:  class_hit = w.fp_en;
            KIND_VEC: class_hit = w.vec_en;
            default:  class_hit = 1'b0;
        endcase
    endfunction

    function automatic logic [TMR_W-1:0] tmr_step(logic [TMR_W-1:0] t);
        tmr_step = (t == TMR_W'(TMR_TOP)) ? t : t + 1'b1;
    endfunction

endpackage

// File: rtl/wct_wake_sel.sv
module wct_wake_sel
    import wct_pkg::*;
#(
    parameter int NUM_WK  = 2,
    parameter int NUM_LDP = 2,
    parameter int NUM_EXU = 4,
    parameter int TAG_W   = 6
) (
    input  logic [TAG_W-1:0]              src_tag,
    input  src_kind_e                     src_kind,
    input  logic [NUM_WK-1:0]             wk_valid,
    input  logic [NUM_WK*TAG_W-1:0]       wk_tag,
    input  logic [NUM_WK*3-1:0]           wk_wen,
    input  logic [NUM_WK*NUM_EXU-1:0]     wk_oh,
    input  logic [NUM_WK*NUM_LDP*DEP_W-1:0] wk_ldep,
    output logic                          hit,
    output logic [NUM_LDP*DEP_W-1:0]      sel_ldep,
    output logic [NUM_EXU-1:0]            sel_oh
);
    localparam int LD_BITS = NUM_LDP * DEP_W;

    always_comb begin
        hit      = 1'b0;
        sel_ldep = '0;
        sel_oh   = '0;
        // descending scan: the lowest matching port is written last and wins
        for (int w = NUM_WK - 1; w >= 0; w--) begin
            if (wk_valid[w] && (wk_tag[w*TAG_W +: TAG_W] == src_tag) &&
                class_hit(src_kind, wen_t'(wk_wen[w*3 +: 3]))) begin
                hit      = 1'b1;
                sel_ldep = wk_ldep[w*LD_BITS +: LD_BITS];
                sel_oh   = wk_oh[w*NUM_EXU +: NUM_EXU];
            end
        end
    end
endmodule

// File: rtl/wct_cancel_eval.sv
module wct_cancel_eval
    import wct_pkg::*;
#(
    parameter int NUM_LDP = 2,
    parameter int NUM_EXU = 4,
    parameter int TAG_W   = 6
) (
    input  logic                     rdy_q,
    input  src_kind_e                kind_q,
    input  logic [TAG_W-1:0]         tag_q,
    input  logic [NUM_LDP*DEP_W-1:0] ldep_q,
    input  logic [NUM_EXU-1:0]       oh_q,
    input  logic [TMR_W-1:0]         tmr_q,
    input  logic [NUM_LDP-1:0]       ldc1,
    input  logic [NUM_LDP-1:0]       ldc2,
    input  logic [NUM_EXU-1:0]       og0_oh,
    input  logic                     cb_valid,
    input  logic [TAG_W-1:0]         cb_tag,
    input  logic                     cb_int,
    output logic                     cancel
);
    logic ld_kill, og_kill, cb_kill, cb_class;

    always_comb begin
        ld_kill = 1'b0;
        for (int p = 0; p < NUM_LDP; p++) begin
            ld_kill = ld_kill | (ldc1[p] & ldep_q[p*DEP_W + 1])
                              | (ldc2[p] & ldep_q[p*DEP_W + 2]);
        end
        og_kill  = (|(oh_q & og0_oh)) && (tmr_q == TMR_W'(1));
        cb_class = (kind_q == KIND_INT) ? cb_int : !cb_int;
        cb_kill  = cb_valid && (cb_tag == tag_q) && cb_class;
        cancel   = rdy_q && (kind_q != KIND_IMM) && (ld_kill || og_kill || cb_kill);
    end
endmodule

// File: rtl/wct_src_slot.sv
module wct_src_slot
    import wct_pkg::*;
#(
    parameter int NUM_WK  = 2,
    parameter int NUM_LDP = 2,
    parameter int NUM_EXU = 4,
    parameter int TAG_W   = 6
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            alloc_i,
    input  logic [TAG_W-1:0]                alloc_tag,
    input  src_kind_e                       alloc_kind,
    input  logic                            alloc_rdy,
    input  logic [NUM_WK-1:0]               wk_valid,
    input  logic [NUM_WK*TAG_W-1:0]         wk_tag,
    input  logic [NUM_WK*3-1:0]             wk_wen,
    input  logic [NUM_WK*NUM_EXU-1:0]       wk_oh,
    input  logic [NUM_WK*NUM_LDP*DEP_W-1:0] wk_ldep,
    input  logic [NUM_LDP-1:0]              ldc1,
    input  logic [NUM_LDP-1:0]              ldc2,
    input  logic [NUM_EXU-1:0]              og0_oh,
    input  logic                            cb_valid,
    input  logic [TAG_W-1:0]                cb_tag,
    input  logic                            cb_int,
    output logic                            ready,
    output logic                            cancel
);
    localparam int LD_BITS = NUM_LDP * DEP_W;

    logic               rdy_q;
    src_kind_e          kind_q;
    logic [TAG_W-1:0]   tag_q;
    logic [LD_BITS-1:0] ldep_q, ldep_aged, sel_ldep;
    logic [NUM_EXU-1:0] oh_q, sel_oh;
    logic [TMR_W-1:0]   tmr_q;
    logic               hit;

    wct_wake_sel #(.NUM_WK(NUM_WK), .NUM_LDP(NUM_LDP), .NUM_EXU(NUM_EXU), .TAG_W(TAG_W)) u_sel (
        .src_tag(tag_q), .src_kind(kind_q), .wk_valid(wk_valid), .wk_tag(wk_tag),
        .wk_wen(wk_wen), .wk_oh(wk_oh), .wk_ldep(wk_ldep),
        .hit(hit), .sel_ldep(sel_ldep), .sel_oh(sel_oh)
    );

    wct_cancel_eval #(.NUM_LDP(NUM_LDP), .NUM_EXU(NUM_EXU), .TAG_W(TAG_W)) u_cxl (
        .rdy_q(rdy_q), .kind_q(kind_q), .tag_q(tag_q), .ldep_q(ldep_q), .oh_q(oh_q),
        .tmr_q(tmr_q), .ldc1(ldc1), .ldc2(ldc2), .og0_oh(og0_oh),
        .cb_valid(cb_valid), .cb_tag(cb_tag), .cb_int(cb_int), .cancel(cancel)
    );

    always_comb begin
        for (int p = 0; p < NUM_LDP; p++) begin
            ldep_aged[p*DEP_W +: DEP_W] = {ldep_q[p*DEP_W +: DEP_W-1], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_q  <= 1'b0;
            kind_q <= KIND_INT;
            tag_q  <= '0;
            ldep_q <= '0;
            oh_q   <= '0;
            tmr_q  <= '0;
        end else if (alloc_i) begin
            rdy_q  <= alloc_rdy;
            kind_q <= alloc_kind;
            tag_q  <= alloc_tag;
            ldep_q <= '0;
            oh_q   <= '0;
            tmr_q  <= '0;
        end else if (hit) begin
            rdy_q  <= 1'b1;
            ldep_q <= sel_ldep;
            oh_q   <= sel_oh;
            tmr_q  <= '0;
        end else if (cancel) begin
            rdy_q  <= 1'b0;
            ldep_q <= '0;
            oh_q   <= '0;
            tmr_q  <= '0;
        end else begin
            ldep_q <= ldep_aged;
            tmr_q  <= tmr_step(tmr_q);
        end
    end

    assign ready = (kind_q == KIND_IMM) || rdy_q;

    assert_hit_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (hit && !alloc_i) |=> rdy_q);

    assert_cancel_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (cancel && !hit && !alloc_i) |=> (!rdy_q && tmr_q == '0));

    assert_idle_dep_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !rdy_q |-> (ldep_q == '0));

    assert_dep_shift_R5: assert property (@(posedge clk) disable iff (rst)
        (!hit && !alloc_i && !cancel) |=> (ldep_q[DEP_W-1:0] == {$past(ldep_q[DEP_W-2:0]), 1'b0}));

    assert_tmr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (tmr_q == TMR_W'(TMR_TOP) && !hit && !alloc_i && !cancel) |=> (tmr_q == TMR_W'(TMR_TOP)));
endmodule

// File: rtl/wakeup_cancel_tracker.sv
module wakeup_cancel_tracker
    import wct_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int NUM_WK  = 2,
    parameter int NUM_LDP = 2,
    parameter int NUM_EXU = 4,
    parameter int TAG_W   = 6
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            alloc_i,
    input  logic [NUM_SRC*TAG_W-1:0]        alloc_tag_i,
    input  logic [NUM_SRC*2-1:0]            alloc_kind_i,
    input  logic [NUM_SRC-1:0]              alloc_rdy_i,
    input  logic [NUM_WK-1:0]               wk_valid_i,
    input  logic [NUM_WK*TAG_W-1:0]         wk_tag_i,
    input  logic [NUM_WK*3-1:0]             wk_wen_i,
    input  logic [NUM_WK*NUM_EXU-1:0]       wk_exu_oh_i,
    input  logic [NUM_WK*NUM_LDP*3-1:0]     wk_ldep_i,
    input  logic [NUM_LDP-1:0]              ldc1_i,
    input  logic [NUM_LDP-1:0]              ldc2_i,
    input  logic [NUM_EXU-1:0]              og0_cancel_i,
    input  logic                            cb_valid_i,
    input  logic [TAG_W-1:0]                cb_tag_i,
    input  logic                            cb_int_i,
    output logic [NUM_SRC-1:0]              src_ready_o,
    output logic                            cancel_o
);
    logic [NUM_SRC-1:0] slot_cancel;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
        wct_src_slot #(.NUM_WK(NUM_WK), .NUM_LDP(NUM_LDP), .NUM_EXU(NUM_EXU), .TAG_W(TAG_W)) u_slot (
            .clk(clk), .rst(rst), .alloc_i(alloc_i),
            .alloc_tag(alloc_tag_i[s*TAG_W +: TAG_W]),
            .alloc_kind(src_kind_e'(alloc_kind_i[s*2 +: 2])),
            .alloc_rdy(alloc_rdy_i[s]),
            .wk_valid(wk_valid_i), .wk_tag(wk_tag_i), .wk_wen(wk_wen_i),
            .wk_oh(wk_exu_oh_i), .wk_ldep(wk_ldep_i),
            .ldc1(ldc1_i), .ldc2(ldc2_i), .og0_oh(og0_cancel_i),
            .cb_valid(cb_valid_i), .cb_tag(cb_tag_i), .cb_int(cb_int_i),
            .ready(src_ready_o[s]), .cancel(slot_cancel[s])
        );
    end

    assign cancel_o = |slot_cancel;

    assert_alloc_imm_ready_R2: assert property (@(posedge clk) disable iff (rst)
        (alloc_i && alloc_kind_i[1:0] == 2'd3) |=> src_ready_o[0]);
endmodule

// File: tb/wakeup_cancel_tracker_bench.sv
module wakeup_cancel_tracker_bench;
    localparam int NS = 2, NW = 2, NL = 2, NE = 4, TW = 6;

    logic clk = 1'b0;
    logic rst;
    logic alloc_i;
    logic [NS*TW-1:0] alloc_tag_i;
    logic [NS*2-1:0]  alloc_kind_i;
    logic [NS-1:0]    alloc_rdy_i;
    logic [NW-1:0]    wk_valid_i;
    logic [NW*TW-1:0] wk_tag_i;
    logic [NW*3-1:0]  wk_wen_i;
    logic [NW*NE-1:0] wk_exu_oh_i;
    logic [NW*NL*3-1:0] wk_ldep_i;
    logic [NL-1:0]    ldc1_i, ldc2_i;
    logic [NE-1:0]    og0_cancel_i;
    logic             cb_valid_i, cb_int_i;
    logic [TW-1:0]    cb_tag_i;
    logic [NS-1:0]    src_ready_o;
    logic             cancel_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wakeup_cancel_tracker #(.NUM_SRC(NS), .NUM_WK(NW), .NUM_LDP(NL), .NUM_EXU(NE), .TAG_W(TW))
    u_wakeup_cancel_tracker (
        .clk(clk), .rst(rst), .alloc_i(alloc_i), .alloc_tag_i(alloc_tag_i),
        .alloc_kind_i(alloc_kind_i), .alloc_rdy_i(alloc_rdy_i), .wk_valid_i(wk_valid_i),
        .wk_tag_i(wk_tag_i), .wk_wen_i(wk_wen_i), .wk_exu_oh_i(wk_exu_oh_i),
        .wk_ldep_i(wk_ldep_i), .ldc1_i(ldc1_i), .ldc2_i(ldc2_i), .og0_cancel_i(og0_cancel_i),
        .cb_valid_i(cb_valid_i), .cb_tag_i(cb_tag_i), .cb_int_i(cb_int_i),
        .src_ready_o(src_ready_o), .cancel_o(cancel_o)
    );

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic clr();
        alloc_i = 0; alloc_tag_i = '0; alloc_kind_i = '0; alloc_rdy_i = '0;
        wk_valid_i = '0; wk_tag_i = '0; wk_wen_i = '0; wk_exu_oh_i = '0; wk_ldep_i = '0;
        ldc1_i = '0; ldc2_i = '0; og0_cancel_i = '0;
        cb_valid_i = 0; cb_tag_i = '0; cb_int_i = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // src0: kind k0 tag 5; src1: fp tag 9 not ready
    task automatic setup(int k0, logic r0);
        clr();
        alloc_i = 1;
        alloc_tag_i = {TW'(9), TW'(5)};
        alloc_kind_i = {2'd1, 2'(k0)};
        alloc_rdy_i = {1'b0, r0};
        tick(); clr();
    endtask

    task automatic set_wake(int w, int tag, int wen, int oh, int dep0, int dep1);
        wk_valid_i[w] = 1;
        wk_tag_i[w*TW +: TW] = TW'(tag);
        wk_wen_i[w*3 +: 3] = 3'(wen);
        wk_exu_oh_i[w*NE +: NE] = NE'(oh);
        wk_ldep_i[(w*NL)*3 +: 3] = 3'(dep0);
        wk_ldep_i[(w*NL+1)*3 +: 3] = 3'(dep1);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        clr();
        rst = 1;
        repeat (3) tick();
        rst = 0;
        // R1 reset state
        check("R1 ready0", src_ready_o[0], 1'b0);
        check("R1 ready1", src_ready_o[1], 1'b0);
        check("R1 cancel", cancel_o, 1'b0);

        // R2/R3/R4 sweep: class x enables x tag match x valid
        for (int k = 0; k < 4; k++)
            for (int wen = 0; wen < 8; wen++)
                for (int m = 0; m < 2; m++)
                    for (int v = 0; v < 2; v++) begin
                        logic exp;
                        setup(k, 1'b0);
                        check("R2 alloc ready", src_ready_o[0], logic'(k == 3));
                        set_wake(1, m ? 5 : 6, wen, 0, 0, 0);
                        wk_valid_i[1] = 1'(v);
                        tick(); clr();
                        exp = (k == 3) || (v == 1 && m == 1 && ((wen >> k) & 1) == 1);
                        check("R3 R4 wake", src_ready_o[0], exp);
                    end

        // R5/R6/R7 dependency aging sweep on pipe 0
        for (int d = 1; d < 8; d++)
            for (int k = 0; k < 4; k++)
                for (int st = 1; st < 3; st++) begin
                    logic exp;
                    setup(0, 1'b0);
                    set_wake(0, 5, 1, 0, d, 0);
                    tick(); clr();
                    repeat (k) tick();
                    if (st == 1) ldc1_i[1] = 1; else ldc2_i[1] = 1;
                    #2 check("R6 other pipe ignored", cancel_o, 1'b0);
                    clr();
                    if (st == 1) ldc1_i[0] = 1; else ldc2_i[0] = 1;
                    exp = logic'((((d << k) & 7) >> st) & 1);
                    #2 check(st == 1 ? "R6 stage1 cancel" : "R7 stage2 cancel", cancel_o, exp);
                    tick(); clr();
                    check("R10 ready after cancel", src_ready_o[0], !exp);
                    check("R10 other source", src_ready_o[1], 1'b0);
                end

        // R8 og0 cancel sweep: unit x cancel one-hot x age
        for (int u = 0; u < NE; u++)
            for (int c = 0; c < NE; c++)
                for (int k = 0; k < 9; k++) begin
                    logic exp;
                    setup(2, 1'b0);
                    set_wake(1, 5, 4, 1 << u, 0, 0);
                    tick(); clr();
                    repeat (k) tick();
                    og0_cancel_i = NE'(1 << c);
                    exp = (u == c) && (k == 1);
                    #2 check("R8 og0 cancel", cancel_o, exp);
                    tick(); clr();
                    check("R8 ready", src_ready_o[0], !exp);
                end

        // R9 broadcast cancel sweep
        for (int k = 0; k < 3; k++)
            for (int ci = 0; ci < 2; ci++)
                for (int m = 0; m < 2; m++) begin
                    logic exp;
                    setup(k, 1'b1);
                    cb_valid_i = 1; cb_tag_i = TW'(m ? 5 : 7); cb_int_i = 1'(ci);
                    exp = (m == 1) && ((k == 0) ? (ci == 1) : (ci == 0));
                    #2 check("R9 broadcast cancel", cancel_o, exp);
                    tick();
                    check("R9 ready", src_ready_o[0], !exp);
                    #2 check("R10 unready not cancelled", cancel_o, 1'b0);
                    clr();
                end

        // R11 wake beats cancel, new dependency captured
        setup(0, 1'b0);
        set_wake(0, 5, 1, 0, 1, 0);
        tick(); clr(); tick();
        ldc1_i[0] = 1;
        set_wake(1, 5, 1, 0, 0, 0);
        #2 check("R11 cancel seen", cancel_o, 1'b1);
        tick(); clr();
        check("R11 stays ready", src_ready_o[0], 1'b1);
        tick();
        ldc1_i[0] = 1;
        #2 check("R11 new dep used", cancel_o, 1'b0);
        tick(); clr();
        // R2 alloc beats wake
        alloc_i = 1; alloc_tag_i = {TW'(9), TW'(5)}; alloc_kind_i = 4'b0100;
        set_wake(0, 5, 1, 0, 0, 0);
        tick(); clr();
        check("R2 alloc over wake", src_ready_o[0], 1'b0);

        // R12 lowest port wins
        for (int r = 0; r < 2; r++) begin
            setup(0, 1'b0);
            set_wake(0, 5, 1, 0, r ? 0 : 1, 0);
            set_wake(1, 5, 1, 0, r ? 1 : 0, 0);
            tick(); clr(); tick();
            ldc1_i[0] = 1;
            #2 check("R12 port priority", cancel_o, logic'(r == 0));
            tick(); clr();
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule